// File: doc/BRIEF.md
# Row-latched EEPROM write controller

This block controls a small byte-wide nonvolatile data array of 256 bytes, arranged as 8 rows of 32 bytes. A CPU reaches it over a simple bus with an address, write data, read data, a write strobe, a read strobe, and a select line that picks either the array or a single control/status register. When the latch-enable bit is clear, the array behaves like ROM. Reads return the stored cells and writes have no effect.

Software sets the latch-enable bit to enter write mode. Each array write then goes into one of 32 byte latches, chosen by the low five address bits. A second write to the same latch keeps the bitwise AND of the old and new data. Setting the program bit starts one programming cycle. That cycle copies every latch that holds a byte into the row named by the upper address bits of the most recent write. It lasts a parameterised number of clocks, and at the end the hardware clears both control bits together. The array cells are a register array and the programming time is a cycle counter.

Top module: `eeprom_row_ctrl`

## Requirements
- R1: After reset the status register reads 0 and every array byte reads 0xFF.
- R2: With latch-enable at 0, an array write changes nothing, and an array read returns the stored cell byte.
- R3: With latch-enable at 1, an array write is captured in the latch selected by addr[4:0], and it does not appear in the array before programming. An array read still returns the cell content, never latch content.
- R4: A programming cycle writes each latch that holds a byte into the row given by addr[7:5] of the last latched write. The cell takes the latch value directly, with no AND against the old cell. Bytes with no latched write keep their old value.
- R5: Programming lasts PROG_CYCLES clocks, during which the status register reads 0x07. Latch-enable and program are cleared in the same cycle when programming ends, after which the status register reads 0x00.
- R6: A repeated write to a latch before programming stores the AND of the held and new data.
- R7: Latches return to empty (0xFF, not valid) at the end of each programming cycle and whenever latch-enable falls from 1 to 0.
- R8: While programming is in progress, array writes and control register writes are ignored.
- R9: Writing the program bit while latch-enable is 0 is ignored. Programming with no latched bytes completes without changing the array.
- R10: Status register layout: bit 0 latch-enable, bit 1 program, bit 2 busy, other bits 0. A programming cycle starts on a control write with bits 1 and 0 both set while latch-enable is already 1. Read data appears on rdata_o on the clock edge that samples rd_i and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_csr_i | input | 1 | 1 selects the control/status register, 0 the array |
| addr_i | input | 8 | Array byte address (row in [7:5], column in [4:0]) |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Registered read data |

## Verification
The in-line assertions check four things on every cycle: the AND merge of a latch on each write, that latches are empty after every clear, that the program and latch-enable bits fall together, and that programming only starts with latch-enable already set. They also check that no latch holds a byte while latch-enable is 0, and that a committed latch lands in the right cell. Only the bench scenarios can show four other behaviours at the bus. The first is choosing the row from the last write. The second is that unlatched bytes are kept. The third is that writes made during programming are ignored. The fourth is that latches dropped by a fall of latch-enable never reach a later program.

// File: rtl/eeprom_row_pkg.sv
`timescale 1ns/1ps
package eeprom_row_pkg;
  localparam int unsigned LAT_BIT  = 0;
  localparam int unsigned PGM_BIT  = 1;
  localparam int unsigned BUSY_BIT = 2;
endpackage

// File: rtl/row_prog_fsm.sv
`timescale 1ns/1ps
module row_prog_fsm #(
  parameter int unsigned PROG_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       csr_wr_i,
  input  logic [1:0] csr_wdata_i,  // [1]=pgm, [0]=lat
  input  logic       arr_wr_i,
  output logic       lat_o,
  output logic       pgm_o,
  output logic       latch_wr_o,
  output logic       latch_clr_o,
  output logic       commit_o
);
  localparam int unsigned CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

  logic             lat_q, pgm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start, lat_fall;

  assign commit_o    = pgm_q && (cnt_q == CNT_W'(PROG_CYCLES - 1));
  assign start       = csr_wr_i && !pgm_q && lat_q && csr_wdata_i[0] && csr_wdata_i[1];
  assign lat_fall    = csr_wr_i && !pgm_q && lat_q && !csr_wdata_i[0];
  assign latch_wr_o  = arr_wr_i && lat_q && !pgm_q;
  assign latch_clr_o = commit_o || lat_fall;
  assign lat_o       = lat_q;
  assign pgm_o       = pgm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
      pgm_q <= 1'b0;
      cnt_q <= '0;
    end else if (commit_o) begin
      lat_q <= 1'b0;
      pgm_q <= 1'b0;
      cnt_q <= '0;
    end else if (pgm_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (csr_wr_i) begin
      lat_q <= csr_wdata_i[0];
      if (start) begin
        pgm_q <= 1'b1;
        cnt_q <= '0;
      end
    end
  end

  p_clear_together_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pgm_q) |-> $fell(lat_q));
  p_pgm_needs_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgm_q) |-> $past(lat_q));
  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_q && !commit_o) |=> (pgm_q && lat_q));
endmodule

// File: rtl/row_latch_buf.sv
`timescale 1ns/1ps
module row_latch_buf #(
  parameter int unsigned ROW_BYTES = 32,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ROW_W     = 3,
  localparam int unsigned COL_W    = $clog2(ROW_BYTES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic                             clr_i,
  input  logic [COL_W-1:0]                 col_i,
  input  logic [ROW_W-1:0]                 row_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [ROW_BYTES-1:0][DATA_W-1:0] data_o,
  output logic [ROW_BYTES-1:0]             valid_o,
  output logic [ROW_W-1:0]                 row_o
);
  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[b]  <= '1;
        valid_o[b] <= 1'b0;
      end else if (clr_i) begin
        data_o[b]  <= '1;
        valid_o[b] <= 1'b0;
      end else if (wr_i && (col_i == COL_W'(b))) begin
        data_o[b]  <= data_o[b] & data_i;  // cleared value is all ones
        valid_o[b] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   row_o <= '0;
    else if (wr_i) row_o <= row_i;
  end

  p_and_merge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> (data_o[$past(col_i)] == ($past(data_o[col_i]) & $past(data_i))));
  p_cleared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((valid_o == '0) && (&data_o)));
endmodule

// File: rtl/cell_array.sv
`timescale 1ns/1ps
module cell_array #(
  parameter int unsigned ROWS      = 8,
  parameter int unsigned ROW_BYTES = 32,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned COL_W    = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W    = $clog2(ROWS),
  localparam int unsigned ADDR_W   = ROW_W + COL_W,
  localparam int unsigned DEPTH    = ROWS * ROW_BYTES
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             commit_i,
  input  logic [ROW_W-1:0]                 row_i,
  input  logic [ROW_BYTES-1:0][DATA_W-1:0] ldata_i,
  input  logic [ROW_BYTES-1:0]             lvalid_i,
  input  logic [ADDR_W-1:0]                raddr_i,
  output logic [DATA_W-1:0]                rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      for (int b = 0; b < ROW_BYTES; b++)
        if (lvalid_i[b]) mem_q[{row_i, COL_W'(b)}] <= ldata_i[b];
    end
  end

  assign rdata_o = mem_q[raddr_i];

  p_commit_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && lvalid_i[0]) |=> (mem_q[{$past(row_i), COL_W'(0)}] == $past(ldata_i[0])));
endmodule

// File: rtl/eeprom_row_ctrl.sv
`timescale 1ns/1ps
module eeprom_row_ctrl #(
  parameter int unsigned ROWS        = 8,
  parameter int unsigned ROW_BYTES   = 32,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PROG_CYCLES = 8,
  localparam int unsigned COL_W      = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W      = $clog2(ROWS),
  localparam int unsigned ADDR_W     = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_csr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o
);
  import eeprom_row_pkg::*;

  logic                             lat, pgm, latch_wr, latch_clr, commit;
  logic [ROW_BYTES-1:0][DATA_W-1:0] ldata;
  logic [ROW_BYTES-1:0]             lvalid;
  logic [ROW_W-1:0]                 lrow;
  logic [DATA_W-1:0]                cell_rd, status;

  row_prog_fsm #(.PROG_CYCLES(PROG_CYCLES)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_wr_i    (wr_i && sel_csr_i),
    .csr_wdata_i (wdata_i[1:0]),
    .arr_wr_i    (wr_i && !sel_csr_i),
    .lat_o       (lat),
    .pgm_o       (pgm),
    .latch_wr_o  (latch_wr),
    .latch_clr_o (latch_clr),
    .commit_o    (commit)
  );

  row_latch_buf #(.ROW_BYTES(ROW_BYTES), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (latch_wr),
    .clr_i   (latch_clr),
    .col_i   (addr_i[COL_W-1:0]),
    .row_i   (addr_i[ADDR_W-1:COL_W]),
    .data_i  (wdata_i),
    .data_o  (ldata),
    .valid_o (lvalid),
    .row_o   (lrow)
  );

  cell_array #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .DATA_W(DATA_W)) u_cells (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .row_i    (lrow),
    .ldata_i  (ldata),
    .lvalid_i (lvalid),
    .raddr_i  (addr_i),
    .rdata_o  (cell_rd)
  );

  always_comb begin
    status           = '0;
    status[LAT_BIT]  = lat;
    status[PGM_BIT]  = pgm;
    status[BUSY_BIT] = pgm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= sel_csr_i ? status : cell_rd;
  end

  p_idle_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat |-> (lvalid == '0));
endmodule

// File: tb/eeprom_row_ctrl_test.sv
`timescale 1ns/1ps
module eeprom_row_ctrl_test;
  localparam int P = 8;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       sel_csr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;

  eeprom_row_ctrl #(.PROG_CYCLES(P)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_csr_i(sel_csr), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata)
  );

  always #10 clk = ~clk;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb_q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit rd_seen = 0, done = 0;

  // reference model
  logic [7:0] m_mem [256];
  logic [7:0] m_l [32];
  bit         m_v [32];
  bit         m_lat = 0, m_busy = 0;
  logic [2:0] m_row = '0;
  int         start = 0;

  always @(posedge clk) begin
    cyc++;
    rd_seen <= rd;
  end

  // monitor
  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: got %h exp <none>", rdata);
      end else begin
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h exp %h", it.req, rdata, it.exp);
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic clr_latches();
    for (int i = 0; i < 32; i++) begin m_l[i] = 8'hFF; m_v[i] = 0; end
  endtask

  task automatic do_rd(input bit csr, input logic [7:0] a, input logic [7:0] e, input string req);
    item_t it;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    sel_csr = csr; addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_arr(input logic [7:0] a, input string req);
    do_rd(0, a, m_mem[a], req);
  endtask

  task automatic arr_wr(input logic [7:0] a, input logic [7:0] d);
    sel_csr = 0; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (!m_busy && m_lat) begin
      m_l[a[4:0]] = m_l[a[4:0]] & d;
      m_v[a[4:0]] = 1;
      m_row = a[7:5];
    end
  endtask

  task automatic csr_wr(input logic [7:0] d);
    sel_csr = 1; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (!m_busy) begin
      if (m_lat && d[0] && d[1]) begin
        m_busy = 1;
        start = cyc;
      end else begin
        if (m_lat && !d[0]) clr_latches();
        m_lat = d[0];
      end
    end
  endtask

  task automatic finish_prog();
    while (cyc < start + P - 1) @(negedge clk);
    do_rd(1, 8'h00, 8'h07, "R5 busy in last cycle");
    for (int i = 0; i < 32; i++) if (m_v[i]) m_mem[{m_row, 5'(i)}] = m_l[i];
    clr_latches();
    m_lat = 0; m_busy = 0;
    do_rd(1, 8'h00, 8'h00, "R5 both bits cleared");
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
    clr_latches();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    do_rd(1, 8'h00, 8'h00, "R1 status");
    rd_arr(8'h00, "R1 cell");
    rd_arr(8'hA5, "R1 cell");

    arr_wr(8'h10, 8'h00);
    rd_arr(8'h10, "R2 write ignored");

    csr_wr(8'h02);
    do_rd(1, 8'h00, 8'h00, "R9 pgm without lat");

    csr_wr(8'h01);
    do_rd(1, 8'h00, 8'h01, "R10 lat bit");
    arr_wr(8'h23, 8'h5A);
    arr_wr(8'h27, 8'h3C);
    rd_arr(8'h23, "R3 no latch readback");
    arr_wr(8'h41, 8'h81);
    csr_wr(8'h03);
    finish_prog();
    rd_arr(8'h43, "R4 row of last write");
    rd_arr(8'h47, "R4 row of last write");
    rd_arr(8'h41, "R4 row of last write");
    rd_arr(8'h23, "R4 other row kept");
    rd_arr(8'h42, "R4 unlatched kept");

    csr_wr(8'h01);
    arr_wr(8'h60, 8'hF0);
    arr_wr(8'h60, 8'h3C);
    csr_wr(8'h03);
    finish_prog();
    rd_arr(8'h60, "R6 and merge");

    csr_wr(8'h01);
    arr_wr(8'h43, 8'hA5);
    csr_wr(8'h03);
    finish_prog();
    rd_arr(8'h43, "R4 direct overwrite");

    csr_wr(8'h01);
    arr_wr(8'h80, 8'h00);
    csr_wr(8'h00);
    csr_wr(8'h01);
    arr_wr(8'h81, 8'h11);
    csr_wr(8'h03);
    finish_prog();
    rd_arr(8'h80, "R7 cleared by lat fall");
    rd_arr(8'h81, "R7 later byte programmed");

    csr_wr(8'h01);
    arr_wr(8'h82, 8'h22);
    csr_wr(8'h03);
    finish_prog();
    csr_wr(8'h01);
    arr_wr(8'hA0, 8'h77);
    csr_wr(8'h03);
    finish_prog();
    rd_arr(8'h82, "R7 first program");
    rd_arr(8'hA2, "R7 cleared at end of program");
    rd_arr(8'hA0, "R4 second program");

    csr_wr(8'h01);
    arr_wr(8'hC5, 8'h6B);
    csr_wr(8'h03);
    arr_wr(8'hC5, 8'h00);
    csr_wr(8'h00);
    finish_prog();
    rd_arr(8'hC5, "R8 writes during busy ignored");

    csr_wr(8'h01);
    csr_wr(8'h03);
    finish_prog();
    rd_arr(8'hC5, "R9 empty program");
    rd_arr(8'h00, "R9 empty program");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule